// File: doc/BRIEF.md
# Four-State Trellis Path-Metric Engine

This block is the add-compare-select core of a hard-decision decoder for the constraint-length-3, rate-1/2 convolutional code. The decoder has four trellis states. On each cycle that carries a received two-bit symbol, the block updates all four states at once. For every state it measures the Hamming distance between the received symbol and the symbol expected on each of the two branches that enter the state. It adds each distance to the path metric of that branch's source state. It keeps the smaller sum and records one survivor decision bit. A traceback unit placed downstream consumes the four-bit decision vector together with the step strobe.

A restart pulse reloads the initial metrics. The initial metrics are either all zero or biased toward state 00 when the encoder is known to have started there. A small two-phase controller tracks whether the trellis has been freshly initialised (`PH_FRESH`) or has taken at least one step (`PH_RUN`). The controller has these transitions:
- reset goes to `PH_FRESH`.
- `PH_FRESH` goes to `PH_RUN` on an accepted symbol.
- `PH_RUN` goes to `PH_FRESH` on a restart without a symbol.
- a restart that coincides with a symbol lands in `PH_RUN`.

Path metrics saturate rather than wrap.

Top module: `viterbi_acs`

## Requirements
- R1: The branch metric is the count of differing bits between the received symbol and the branch's expected symbol, so it is 0, 1 or 2.
- R2: State s is read from `pm_out[s*PM_W +: PM_W]` and its decision from `decision[s]`, where s is the state's two bits read as a number. The branches entering each state are listed as first / second, each with its source state and expected symbol:
  - state 00: from 01 expecting 11 / from 00 expecting 00.
  - state 01: from 11 expecting 01 / from 10 expecting 10.
  - state 10: from 00 expecting 11 / from 01 expecting 00.
  - state 11: from 11 expecting 10 / from 10 expecting 01.
- R3: Each new path metric is the minimum of the two candidate sums, where a candidate sum is the source metric plus the branch metric.
- R4: A decision bit of 0 means the first-listed branch survived and 1 means the second-listed branch survived. When the two sums are equal, the first-listed branch is selected.
- R5: A sum that exceeds 2^PM_W-1 is held at 2^PM_W-1, with PM_W = 8 by default.
- R6: Metrics and decisions update at the clock edge that accepts a symbol (`sym_valid`=1), and `step_valid` is high for exactly the following cycle.
- R7: With neither `sym_valid` nor `restart` asserted, metrics and decisions hold.
- R8: `restart` alone loads all metrics with 0 when `known_start`=0. When `known_start`=1 it loads 0 for state 00 and START_BIAS (default 8) for the other three states.
- R9: When `restart` and `sym_valid` are both asserted, the step is computed from the initial metrics selected by `known_start` instead of the stored ones.
- R10: After reset all metrics are 0, `decision` is 0 and `step_valid` is 0.
- R11: After an unbiased restart, the symbols 11,10,11,11,01,01,11 yield state-00 metrics 0,1,0,2,3,3,0 after steps 1 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Reload initial metrics |
| known_start | input | 1 | Bias initial metrics toward state 00 |
| sym_valid | input | 1 | Received symbol present this cycle |
| sym | input | 2 | Received hard-decision symbol |
| pm_out | output | 4*PM_W | Four path metrics, state s at bits s*PM_W upward |
| decision | output | 4 | Survivor decision per state, 1 = second-listed branch |
| step_valid | output | 1 | One trellis step completed in the previous cycle |

## Verification
Restart and an ACS step can fall in the same cycle. In that case the step must use the fresh initial metrics, not the stored ones. The bench provokes this by raising `restart` and `sym_valid` together after the stored metrics have drifted, with both settings of `known_start`. It judges the result against a bench model that starts from the initial metrics. It also runs every four-symbol sequence after a plain restart, and a long pseudo-random stream that drives the metrics into saturation.

// File: rtl/viterbi_pkg.sv
package viterbi_pkg;
    localparam int NSTATE = 4;

    typedef enum logic {
        PH_FRESH,
        PH_RUN
    } phase_e;

    // First-listed source state of state s
    function automatic int src_first(input int s);
        case (s)
            0: return 1;
            1: return 3;
            2: return 0;
            default: return 3;
        endcase
    endfunction

    // Second-listed source state of state s
    function automatic int src_second(input int s);
        case (s)
            0: return 0;
            1: return 2;
            2: return 1;
            default: return 2;
        endcase
    endfunction

    // Expected symbol on the first-listed branch
    function automatic int exp_first(input int s);
        case (s)
            0: return 3;
            1: return 1;
            2: return 3;
            default: return 2;
        endcase
    endfunction

    // Expected symbol on the second-listed branch
    function automatic int exp_second(input int s);
        case (s)
            0: return 0;
            1: return 2;
            2: return 0;
            default: return 1;
        endcase
    endfunction
endpackage

// File: rtl/vit_bmu.sv
module vit_bmu (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sym,
    output logic [3:0][1:0] bm
);
    // One Hamming distance per possible expected symbol
    for (genvar e = 0; e < 4; e++) begin : g_dist
        logic [1:0] diff;
        assign diff  = sym ^ 2'(e);
        assign bm[e] = {1'b0, diff[1]} + {1'b0, diff[0]};

        assert_bm_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
            bm[e] <= 2'd2)
            else $error("branch metric out of range");
    end
endmodule

// File: rtl/vit_acs_node.sv
module vit_acs_node #(
    parameter int PM_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PM_W-1:0] pm_a,
    input  logic [PM_W-1:0] pm_b,
    input  logic [1:0]      bm_a,
    input  logic [1:0]      bm_b,
    output logic [PM_W-1:0] pm_new,
    output logic            pick_b
);
    localparam logic [PM_W-1:0] PM_MAX = '1;

    logic [PM_W:0]   sum_a, sum_b;
    logic [PM_W-1:0] sat_a, sat_b;

    assign sum_a = {1'b0, pm_a} + (PM_W+1)'(bm_a);
    assign sum_b = {1'b0, pm_b} + (PM_W+1)'(bm_b);
    // R5: clamp instead of wrapping
    assign sat_a = sum_a[PM_W] ? PM_MAX : sum_a[PM_W-1:0];
    assign sat_b = sum_b[PM_W] ? PM_MAX : sum_b[PM_W-1:0];

    // R3/R4: smaller survives, ties keep the first-listed branch
    assign pick_b = (sat_b < sat_a);
    assign pm_new = pick_b ? sat_b : sat_a;

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_new >= pm_a) || (pm_new >= pm_b))
        else $error("survivor metric below both sources");
    assert_tie_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_a == pm_b && bm_a == bm_b) |-> !pick_b)
        else $error("tie did not keep first branch");
endmodule

// File: rtl/viterbi_acs.sv
module viterbi_acs
    import viterbi_pkg::*;
#(
    parameter int PM_W       = 8,
    parameter int START_BIAS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     restart,
    input  logic                     known_start,
    input  logic                     sym_valid,
    input  logic [1:0]               sym,
    output logic [NSTATE*PM_W-1:0]   pm_out,
    output logic [NSTATE-1:0]        decision,
    output logic                     step_valid
);
    localparam logic [PM_W-1:0] BIAS_V = PM_W'(START_BIAS);

    phase_e phase_q, phase_d;

    logic [NSTATE-1:0][PM_W-1:0] pm_q, pm_init, pm_src, pm_nxt;
    logic [NSTATE-1:0]           dec_nxt, dec_q;
    logic                        step_q;
    logic [3:0][1:0]             bm;

    // R8: initial metrics, state 00 unbiased
    always_comb begin
        pm_init = '0;
        for (int s = 1; s < NSTATE; s++)
            pm_init[s] = known_start ? BIAS_V : '0;
    end

    // R9: restart with a symbol steps from the initial metrics
    assign pm_src = restart ? pm_init : pm_q;

    vit_bmu u_bmu (
        .clk  (clk),
        .rst_n(rst_n),
        .sym  (sym),
        .bm   (bm)
    );

    for (genvar s = 0; s < NSTATE; s++) begin : g_node
        localparam int SA = src_first(s);
        localparam int SB = src_second(s);
        localparam int EA = exp_first(s);
        localparam int EB = exp_second(s);
        vit_acs_node #(.PM_W(PM_W)) u_node (
            .clk   (clk),
            .rst_n (rst_n),
            .pm_a  (pm_src[SA]),
            .pm_b  (pm_src[SB]),
            .bm_a  (bm[EA]),
            .bm_b  (bm[EB]),
            .pm_new(pm_nxt[s]),
            .pick_b(dec_nxt[s])
        );
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_FRESH;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_FRESH: if (sym_valid) phase_d = PH_RUN;
            PH_RUN:   if (restart && !sym_valid) phase_d = PH_FRESH;
            default:  phase_d = PH_FRESH;
        endcase
    end

    // Metric, decision and strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_q   <= '0;
            dec_q  <= '0;
            step_q <= 1'b0;
        end else begin
            step_q <= sym_valid;
            if (sym_valid) begin
                pm_q  <= pm_nxt;
                dec_q <= dec_nxt;
            end else if (restart) begin
                pm_q <= pm_init;
            end
        end
    end

    assign pm_out     = pm_q;
    assign decision   = dec_q;
    assign step_valid = step_q;

    assert_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> step_valid)
        else $error("missing step strobe");
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_valid && !restart) |=> ($stable(pm_out) && $stable(decision) && !step_valid))
        else $error("state moved while idle");
    assert_fresh_state00_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !sym_valid) |=> (pm_out[PM_W-1:0] == '0 && phase_q == PH_FRESH))
        else $error("restart did not clear state 00");
    assert_run_after_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> (phase_q == PH_RUN))
        else $error("phase not running after a step");
endmodule

// File: tb/viterbi_acs_bench.sv
module viterbi_acs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PMW  = 8;
    localparam int BIAS = 8;
    localparam int PMAX = (1 << PMW) - 1;

    logic clk = 0;
    logic rst_n, restart, known_start, sym_valid;
    logic [1:0] sym;
    logic [4*PMW-1:0] pm_out;
    logic [3:0] decision;
    logic step_valid;

    int n_cmp = 0, n_bad = 0;
    int m[4];
    int md[4];
    int sat_seen = 0;

    // Source states and expected symbols of each branch, from the requirements
    int sa[4] = '{1, 3, 0, 3};
    int sb[4] = '{0, 2, 1, 2};
    int ea[4] = '{3, 1, 3, 2};
    int eb[4] = '{0, 2, 0, 1};

    always #(CLK_PERIOD/2) clk = ~clk;

    viterbi_acs #(.PM_W(PMW), .START_BIAS(BIAS)) u_viterbi_acs (
        .clk(clk), .rst_n(rst_n), .restart(restart), .known_start(known_start),
        .sym_valid(sym_valid), .sym(sym), .pm_out(pm_out),
        .decision(decision), .step_valid(step_valid)
    );

    function automatic int ham(input int a, input int b);
        int x = a ^ b;
        return (x & 1) + ((x >> 1) & 1);
    endfunction

    task automatic model_init(input int ks);
        m[0] = 0;
        for (int s = 1; s < 4; s++) m[s] = ks ? BIAS : 0;
    endtask

    task automatic model_step(input int y);
        int nm[4];
        for (int s = 0; s < 4; s++) begin
            int ca = m[sa[s]] + ham(y, ea[s]);
            int cb = m[sb[s]] + ham(y, eb[s]);
            if (ca > PMAX) ca = PMAX;
            if (cb > PMAX) cb = PMAX;
            md[s] = (cb < ca) ? 1 : 0;
            nm[s] = (cb < ca) ? cb : ca;
        end
        for (int s = 0; s < 4; s++) m[s] = nm[s];
    endtask

    task automatic compare(input string req, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic check_all(input string req, input int sv);
        int dv = 0;
        for (int s = 0; s < 4; s++) begin
            compare(req, int'(pm_out[s*PMW +: PMW]), m[s]);
            dv |= md[s] << s;
            if (m[s] == PMAX) sat_seen = 1;
        end
        compare(req, int'(decision), dv);
        compare(req, int'(step_valid), sv);
    endtask

    // Drives one cycle; outputs checked at the following negedge
    task automatic cyc(input logic rs, input logic ks, input logic v, input int y);
        restart = rs; known_start = ks; sym_valid = v; sym = 2'(y);
        @(negedge clk);
        restart = 0; sym_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R6 actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int ref_sym[7] = '{3, 2, 3, 3, 1, 1, 3};
        int ref_m0[7]  = '{0, 1, 0, 2, 3, 3, 0};
        logic [15:0] lfsr;
        rst_n = 0; restart = 0; known_start = 0; sym_valid = 0; sym = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        for (int s = 0; s < 4; s++) md[s] = 0;
        model_init(0);
        check_all("R10", 0);

        // R11: reference sequence after unbiased restart
        cyc(1, 0, 0, 0);
        model_init(0);
        for (int s = 0; s < 4; s++) md[s] = 0;
        check_all("R8", 0);
        for (int t = 0; t < 7; t++) begin
            cyc(0, 0, 1, ref_sym[t]);
            model_step(ref_sym[t]);
            compare("R11", int'(pm_out[PMW-1:0]), ref_m0[t]);
            check_all("R3", 1);
        end
        // R7: idle cycles hold everything, strobe drops (R6)
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 0, 3);
            check_all("R7", 0);
        end

        // R1 R2 R3 R4: all four-symbol sequences, both start modes
        for (int ks = 0; ks < 2; ks++) begin
            for (int seq = 0; seq < 256; seq++) begin
                cyc(1, ks[0], 0, 0);
                model_init(ks);
                check_all("R8", 0);
                for (int k = 0; k < 4; k++) begin
                    int y = (seq >> (2*k)) & 3;
                    cyc(0, 0, 1, y);
                    model_step(y);
                    check_all("R2", 1);
                end
            end
        end

        // R9: restart coinciding with a symbol, after metrics drifted
        for (int ks = 0; ks < 2; ks++) begin
            for (int y = 0; y < 4; y++) begin
                cyc(0, 0, 1, 1);
                model_step(1);
                cyc(0, 0, 1, 2);
                model_step(2);
                cyc(1, ks[0], 1, y);
                model_init(ks);
                model_step(y);
                check_all("R9", 1);
            end
        end

        // R5: long pseudo-random stream to drive metrics into saturation
        cyc(1, 0, 0, 0);
        model_init(0);
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            int y;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            y = int'(lfsr[1:0]);
            cyc(0, 0, 1, y);
            model_step(y);
            check_all("R5", 1);
        end
        compare("R5 saturation reached", sat_seen, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule